// File: doc/BRIEF.md
# Framebuffer Control and Interrupt Register File

This block is the register file of a framebuffer controller, sitting on a byte-addressed bus window of 32 bytes. It holds a control byte and a status byte. Bit 7 of the control byte enables the frame interrupt. Bit 7 of the status byte is the pending flag, and reads of the status byte also return fixed identification bits. The upper part of the window gives plain byte storage for cursor and video-timing settings, which other logic consumes.

The display timing logic sends a one-cycle end-of-frame pulse. If interrupts are enabled when that pulse arrives, the pending flag is set and the level interrupt output rises. Software clears the interrupt by writing any value to the status byte. Read data is registered, so it appears one cycle after the read strobe.

Top module: `fbc_regs`

## Requirements
- R1: After reset the control byte, the status flag and every storage byte read as zero, and `irq` is low.
- R2: A write to offset 0x10 stores the full byte. A read of 0x10 returns that byte. Bit 7 is the interrupt enable.
- R3: A read of offset 0x11 returns the pending flag in bit 7, ORed with the constant 0x61 (bits 6 and 5 give the monitor code, bit 0 marks a colour board).
- R4: When `frame_end` is high on a clock edge and control bit 7 is set, the pending flag is set from the next cycle on and `irq` goes high.
- R5: When `frame_end` is high while control bit 7 is clear, neither the flag nor `irq` changes.
- R6: Any write to offset 0x11 clears the pending flag and lowers `irq`, whatever the written data.
- R7: Offsets 0x12 through 0x1F are independent read/write bytes.
- R8: Offsets 0x00 through 0x0F read as zero, and writes to them change no register.
- R9: If `frame_end` with interrupts enabled coincides with a status write, the flag ends up set.
- R10: `rd_data` is valid on the cycle after `rd_en`. `irq` always equals the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 5 | Byte offset in the window |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, one cycle after rd_en |
| frame_end | input | 1 | End-of-frame pulse from timing logic |
| irq | output | 1 | Level interrupt |

## Verification
The main function is exercised by a random mix of writes and reads over the whole window, interleaved with end-of-frame pulses, all compared against a byte-array model. Pulses that arrive with the enable clear, compared with pulses that arrive with it set, separate gating by the enable bit from unconditional setting of the flag. Status writes with random data show that the clear ignores the data. A directed case places a frame pulse on the same edge as a status write, which separates set-priority from clear-priority. Writes to the low window followed by a full readback show whether a stray write has aliased into a mapped register.

// File: rtl/fbc_regs.sv
module fbc_regs #(
  parameter int AW = 5,
  parameter int DW = 8,
  parameter logic [AW-1:0] CTRL_OFS = 5'h10,
  parameter logic [DW-1:0] ID_BITS = 8'h61
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          frame_end,
  output logic          irq
);
  localparam int NSTORE = (1 << AW) - int'(CTRL_OFS) - 2;
  localparam logic [AW-1:0] STAT_OFS = CTRL_OFS + 1'b1;

  logic [DW-1:0] ctrl;
  logic          pend;
  logic [DW-1:0] store [NSTORE];

  wire wr_ctrl  = wr_en && addr == CTRL_OFS;
  wire wr_stat  = wr_en && addr == STAT_OFS;
  wire ev_set   = frame_end && ctrl[DW-1];
  wire in_store = addr > STAT_OFS;
  wire [AW-1:0] sidx = addr - STAT_OFS - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl <= '0;
    else if (wr_ctrl) ctrl <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= 1'b0;
    else if (ev_set) pend <= 1'b1;
    else if (wr_stat) pend <= 1'b0;
  end

  for (genvar i = 0; i < NSTORE; i++) begin : g_store
    always_ff @(posedge clk) begin
      if (!rst_n) store[i] <= '0;
      else if (wr_en && in_store && int'(sidx) == i) store[i] <= wr_data;
    end
  end

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (addr == CTRL_OFS) rd_mux = ctrl;
    else if (addr == STAT_OFS) rd_mux = {pend, {(DW-1){1'b0}}} | ID_BITS;
    else if (in_store) rd_mux = store[sidx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  assign irq = pend;
endmodule

module fbc_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] addr,
  input logic       wr_en,
  input logic       frame_end,
  input logic       irq,
  input logic [7:0] ctrl
);
  // R4
  enable_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && ctrl[7] |=> irq);
  // R5
  gated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && !ctrl[7] && !(wr_en && addr == 5'h11) |=> $stable(irq));
  // R6
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 5'h11 && !(frame_end && ctrl[7]) |=> !irq);
  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 5'h11 && frame_end && ctrl[7] |=> irq);
  // R10
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(frame_end));
endmodule

bind fbc_regs fbc_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
  .frame_end(frame_end), .irq(irq), .ctrl(ctrl)
);

// File: tb/sim_fbc_regs.sv
module sim_fbc_regs;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, frame_end = 0;
  logic [4:0] addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic irq;
  int errors = 0, checks = 0;
  logic [7:0] m_ctrl;
  logic m_pend;
  logic [7:0] m_st [18:31];

  always #2.5 clk = ~clk;

  fbc_regs u0 (.clk, .rst_n, .addr, .wr_en, .wr_data, .rd_en, .rd_data,
               .frame_end, .irq);

  function automatic logic [7:0] exp_rd(input logic [4:0] a);
    if (a == 5'h10) return m_ctrl;
    if (a == 5'h11) return {m_pend, 7'h0} | 8'h61;
    if (a >= 5'h12) return m_st[a];
    return 8'h00;
  endfunction

  task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic [4:0] a, input logic [7:0] d,
                     input logic fe);
    wr_en = w; addr = a; wr_data = d; frame_end = fe; rd_en = 0;
    @(posedge clk);
    if (fe && m_ctrl[7]) m_pend = 1;
    else if (w && a == 5'h11) m_pend = 0;
    if (w && a == 5'h10) m_ctrl = d;
    if (w && a >= 5'h12) m_st[a] = d;
    #1 wr_en = 0; frame_end = 0;
  endtask

  task automatic rd(input string r, input logic [4:0] a);
    addr = a; rd_en = 1; wr_en = 0;
    @(posedge clk); #1 rd_en = 0;
    chk(r, rd_data, exp_rd(a));
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    m_ctrl = 0; m_pend = 0;
    for (int i = 18; i < 32; i++) m_st[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk("R1 irq", {7'h0, irq}, 8'h0);
    for (int i = 16; i < 32; i++) rd("R1", 5'(i));
    // R2 control store
    cyc(1, 5'h10, 8'hA5, 0); rd("R2", 5'h10);
    // R5 disabled frame end
    cyc(1, 5'h10, 8'h00, 0); cyc(0, 0, 0, 1);
    chk("R5 irq", {7'h0, irq}, 8'h0); rd("R5 R3", 5'h11);
    // R4 enabled frame end
    cyc(1, 5'h10, 8'h80, 0); cyc(0, 0, 0, 1);
    chk("R4 R10 irq", {7'h0, irq}, 8'h1); rd("R4 R3", 5'h11);
    // R6 clear with arbitrary data
    cyc(1, 5'h11, 8'h00, 0); chk("R6 irq", {7'h0, irq}, 8'h0);
    cyc(0, 0, 0, 1); cyc(1, 5'h11, 8'hFF, 0); chk("R6 irq", {7'h0, irq}, 8'h0);
    // R9 coincidence
    cyc(1, 5'h11, 8'h55, 1); chk("R9 irq", {7'h0, irq}, 8'h1);
    // R8 low window
    for (int i = 0; i < 16; i++) cyc(1, 5'(i), 8'hFF, 0);
    for (int i = 0; i < 32; i++) rd("R8 R7", 5'(i));
    // R7 storage random
    for (int i = 18; i < 32; i++) cyc(1, 5'(i), 8'($urandom), 0);
    for (int i = 18; i < 32; i++) rd("R7", 5'(i));
    // random mix
    for (int n = 0; n < 2000; n++) begin
      int k = $urandom_range(0, 3);
      logic [4:0] a = 5'($urandom);
      if (k == 0) rd("R2 R3 R7 R8", a);
      else cyc(k == 1, a, 8'($urandom), $urandom_range(0, 3) == 0);
      chk("R10 irq", {7'h0, irq}, {7'h0, m_pend});
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule